// File: doc/BRIEF.md
# Clock/CMOS Register File with Index/Data Access

This block is the host-facing register bank of a real-time clock with battery-style CMOS storage. The host sees two byte-wide locations. A write to the even location selects one of 128 byte slots. Reads and writes at the odd location then act on the selected slot. Slots 0 to 9 hold the time, date and alarm bytes. Slots 10 to 13 are the four control registers A, B, C and D. All other slots are plain storage.

The block keeps the one-second divider. It counts `tick` strobes from a 32768 Hz timebase and issues a `sec_pulse` at each second boundary to an external counting chain. The chain returns new time values in binary on a small write port. The block then stores each value in BCD or binary form, and hours in 12-hour or 24-hour form, as register B selects. The block also produces the periodic, update-ended and alarm flags, and the interrupt line that goes with them.

Top module: `rtc_regfile`

## Requirements
- R1: A host write with `addr_odd`=0 stores `wdata[6:0]` as the slot index. Bit 7 is dropped. A data access with `addr_odd`=1 reaches the indexed slot. A read with `addr_odd`=0 returns 0xFF. Read data appears on `rdata` one clock after `rd_en`.
- R2: After reset, register A (slot 10) reads 0x26, B (slot 11) reads 0x02, C (slot 12) reads 0x00 and D (slot 13) reads 0x80, and `irq` is low. Bit 7 of D is the valid-time bit and always reads 1.
- R3: Host writes to registers C and D have no effect. Bit 7 of register A ignores writes.
- R4: Register C holds IRQF in bit 7, the periodic flag in bit 6, the alarm flag in bit 5 and the update-ended flag in bit 4. A read of C returns the current value, then clears C to 0x00 and lowers `irq`. `irq` follows IRQF.
- R5: Register B holds the periodic, alarm and update-ended enables in bits 6, 5 and 4. A write to B whose enables overlap a flag already set in C sets IRQF and raises `irq` on the next clock. A write to B with no overlap clears IRQF and lowers `irq`.
- R6: While running, bit 7 of register A (UIP) reads 1 during the last `UIP_TICKS` (8) ticks of each second. A second lasts `TICKS_PER_SEC` ticks. At the boundary, UIP returns to 0, the update-ended flag is set and `sec_pulse` pulses for one clock.
- R7: When SET (bit 7 of B) is 1, the divider issues no update and no `sec_pulse`, and UIP reads 0. Writes from the counting chain are ignored in this state. Host writes to time slots are still stored.
- R8: Register A bits 6:4 control the divider. Values 0 to 2 run it, and a value of 6 or 7 holds it in reset. Leaving reset for a running value makes the first update come `TICKS_PER_SEC`/2 ticks later.
- R9: Register A bits 3:0 pick the periodic rate. A value of 0 turns it off. Values 1 and 2 give periods of 128 and 256 ticks. A value n from 3 to 15 gives a period of 2^(n-1) ticks. Each period sets the periodic flag, and sets IRQF as well when the periodic enable is 1.
- R10: A chain write of binary value v to slot 0, 2, 4, 6, 7, 8 or 9 is stored as BCD when B bit 2 is 0, and as binary when it is 1. For slot 4 with B bit 1 = 0 (12-hour mode), hour 0 is stored as 12, hours 13 to 23 as 1 to 11, and bit 7 is set for hours 12 to 23.
- R11: At each update, the alarm flag is set when each alarm slot (1, 3, 5) either equals its time slot (0, 2, 4) or has bits 7:6 = 11 (don't care).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One strobe per 32768 Hz timebase period |
| addr_odd | input | 1 | 0 = index location, 1 = data location |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe (ignored when `wr_en` is high) |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, valid one clock after `rd_en` |
| irq | output | 1 | Interrupt line, mirrors IRQF |
| cnt_we | input | 1 | Counting-chain write strobe |
| cnt_sel | input | 4 | Counting-chain target slot |
| cnt_val | input | 7 | Counting-chain value in binary |
| sec_pulse | output | 1 | One-clock pulse at each second boundary |

## Verification
The bound checker watches several behaviours on every cycle. It checks that a register C read returns the old flags and leaves C and `irq` clear. It checks that writes to B raise or drop `irq` according to the overlap of enables and pending flags. It also checks that every update sets the update-ended flag and pulses `sec_pulse`, that UIP is low right after a boundary, and that SET suppresses UIP and the pulse. Other behaviours can only be shown by the bench scenarios: the exact tick counts of the half-second restart and of the full second, the position of the UIP window, BCD and 12-hour encoding, write protection, alarm matching with don't-care bytes, and the periodic rate.

// File: rtl/rtc_regfile.sv
module rtc_regfile #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int UIP_TICKS     = 8,
  parameter int IDX_W         = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       addr_odd,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq,
  input  logic       cnt_we,
  input  logic [3:0] cnt_sel,
  input  logic [6:0] cnt_val,
  output logic       sec_pulse
);
  localparam int NSLOT = 1 << IDX_W;
  localparam int DIV_W = $clog2(TICKS_PER_SEC);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICKS_PER_SEC - 1);
  localparam logic [DIV_W-1:0] DIV_HALF = DIV_W'(TICKS_PER_SEC / 2);
  localparam logic [DIV_W-1:0] UIP_FROM = DIV_W'(TICKS_PER_SEC - UIP_TICKS);

  localparam logic [IDX_W-1:0] S_SEC  = IDX_W'(0);
  localparam logic [IDX_W-1:0] S_ASEC = IDX_W'(1);
  localparam logic [IDX_W-1:0] S_MIN  = IDX_W'(2);
  localparam logic [IDX_W-1:0] S_AMIN = IDX_W'(3);
  localparam logic [IDX_W-1:0] S_HR   = IDX_W'(4);
  localparam logic [IDX_W-1:0] S_AHR  = IDX_W'(5);
  localparam logic [IDX_W-1:0] S_CTLA = IDX_W'(10);
  localparam logic [IDX_W-1:0] S_CTLB = IDX_W'(11);
  localparam logic [IDX_W-1:0] S_CTLC = IDX_W'(12);
  localparam logic [IDX_W-1:0] S_CTLD = IDX_W'(13);

  logic [IDX_W-1:0] idx;
  logic [7:0]       slot [NSLOT];
  logic [6:0]       ctl_a;
  logic [7:0]       ctl_b;
  logic [7:0]       ctl_c;
  logic [DIV_W-1:0] div_cnt;

  function automatic logic [7:0] to_bcd(input logic [6:0] v);
    logic [6:0] tens, ones;
    tens = v / 7'd10;
    ones = v % 7'd10;
    return {tens[3:0], ones[3:0]};
  endfunction

  function automatic logic [7:0] encode(input logic [6:0] v, input logic is_hr,
                                        input logic bin, input logic h24);
    logic [6:0] h;
    logic [7:0] r;
    h = v;
    if (is_hr && !h24) h = (v % 7'd12 == 7'd0) ? 7'd12 : v % 7'd12;
    r = bin ? {1'b0, h} : to_bcd(h);
    if (is_hr && !h24) r[7] = (v >= 7'd12);
    return r;
  endfunction

  function automatic logic [DIV_W-1:0] rate_mask(input logic [3:0] r);
    int sh;
    sh = (r == 4'd1) ? 7 : (r == 4'd2) ? 8 : int'(r) - 1;
    return DIV_W'((32'd1 << sh) - 32'd1);
  endfunction

  function automatic logic alarm_ok(input logic [7:0] a, input logic [7:0] t);
    return (a[7:6] == 2'b11) || (a == t);
  endfunction

  logic host_rd, data_wr, wr_a, wr_b, rd_c;
  assign host_rd = rd_en && !wr_en;
  assign data_wr = wr_en && addr_odd;
  assign wr_a    = data_wr && idx == S_CTLA;
  assign wr_b    = data_wr && idx == S_CTLB;
  assign rd_c    = host_rd && addr_odd && idx == S_CTLC;

  logic div_run, div_rst, set_mode, uip, at_wrap, upd_evt, per_evt, alm_evt;
  assign div_run  = ctl_a[6:4] <= 3'd2;
  assign div_rst  = ctl_a[6:5] == 2'b11;
  assign set_mode = ctl_b[7];
  assign uip      = div_run && !set_mode && div_cnt >= UIP_FROM;
  assign at_wrap  = div_cnt == DIV_LAST;
  assign upd_evt  = tick && div_run && at_wrap && !set_mode;
  assign per_evt  = tick && div_run && ctl_a[3:0] != 4'd0 &&
                    ((DIV_W'(div_cnt + 1'b1) & rate_mask(ctl_a[3:0])) == '0);
  assign alm_evt  = upd_evt && alarm_ok(slot[S_ASEC], slot[S_SEC]) &&
                    alarm_ok(slot[S_AMIN], slot[S_MIN]) &&
                    alarm_ok(slot[S_AHR], slot[S_HR]);

  logic [7:0] c_base;
  logic [2:0] evts, flags;
  logic       irqf;
  assign c_base = rd_c ? 8'h00 : ctl_c;
  assign evts   = {per_evt, alm_evt, upd_evt};
  assign flags  = c_base[6:4] | evts;
  assign irqf   = wr_b ? |(wdata[6:4] & flags)
                       : (c_base[7] || |(evts & ctl_b[6:4]));
  assign irq    = ctl_c[7];

  logic leave_rst, enter_rst;
  assign enter_rst = wr_a && wdata[6:5] == 2'b11;
  assign leave_rst = wr_a && div_rst && wdata[6:4] <= 3'd2;

  logic cnt_ok;
  assign cnt_ok = cnt_we && !set_mode &&
                  (cnt_sel inside {4'd0, 4'd2, 4'd4, 4'd6, 4'd7, 4'd8, 4'd9});

  logic [7:0] rd_mux;
  always_comb begin
    case (idx)
      S_CTLA:  rd_mux = {uip, ctl_a};
      S_CTLB:  rd_mux = ctl_b;
      S_CTLC:  rd_mux = ctl_c;
      S_CTLD:  rd_mux = 8'h80;
      default: rd_mux = slot[idx];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx       <= '0;
      ctl_a     <= 7'h26;
      ctl_b     <= 8'h02;
      ctl_c     <= 8'h00;
      div_cnt   <= '0;
      rdata     <= 8'h00;
      sec_pulse <= 1'b0;
      for (int i = 0; i < NSLOT; i++) slot[i] <= 8'h00;
    end else begin
      sec_pulse <= upd_evt;
      ctl_c     <= {irqf, flags, 4'b0000};
      if (wr_en && !addr_odd) idx <= wdata[6:0];
      if (cnt_ok)
        slot[IDX_W'(cnt_sel)] <= encode(cnt_val, cnt_sel == 4'd4, ctl_b[2], ctl_b[1]);
      if (data_wr) begin
        case (idx)
          S_CTLA:         ctl_a <= wdata[6:0];
          S_CTLB:         ctl_b <= wdata;
          S_CTLC, S_CTLD: ;
          default:        slot[idx] <= wdata;
        endcase
      end
      if (enter_rst)               div_cnt <= '0;
      else if (leave_rst)          div_cnt <= DIV_HALF;
      else if (tick && div_run)    div_cnt <= at_wrap ? '0 : div_cnt + 1'b1;
      if (host_rd) rdata <= addr_odd ? rd_mux : 8'hFF;
    end
  end
endmodule

module rtc_regfile_chk #(
  parameter int IDX_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             addr_odd,
  input logic             wr_en,
  input logic             rd_en,
  input logic [7:0]       wdata,
  input logic [7:0]       rdata,
  input logic             irq,
  input logic             sec_pulse,
  input logic [IDX_W-1:0] idx,
  input logic [7:0]       ctl_b,
  input logic [7:0]       ctl_c,
  input logic             uip,
  input logic             upd_evt
);
  logic rd_c, wr_b, ovl;
  assign rd_c = rd_en && !wr_en && addr_odd && idx == IDX_W'(12);
  assign wr_b = wr_en && addr_odd && idx == IDX_W'(11);
  assign ovl  = |(wdata[6:4] & ctl_c[6:4]);

  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd_c && !tick |=> ctl_c == 8'h00 && !irq);
  a_r4_read_returns: assert property (@(posedge clk) disable iff (!rst_n)
    rd_c |=> rdata == $past(ctl_c));
  a_r5_enable_raises: assert property (@(posedge clk) disable iff (!rst_n)
    wr_b && ovl |=> irq);
  a_r5_enable_drops: assert property (@(posedge clk) disable iff (!rst_n)
    wr_b && !ovl && !tick |=> !irq);
  a_r6_update_flags: assert property (@(posedge clk) disable iff (!rst_n)
    upd_evt |=> ctl_c[4] && sec_pulse);
  a_r6_uip_after_update: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |-> !uip);
  a_r7_set_no_uip: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_b[7] |-> !uip);
  a_r7_set_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_b[7] |=> !sec_pulse);
  a_r2_d_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !wr_en && addr_odd && idx == IDX_W'(13) |=> rdata == 8'h80);
endmodule

bind rtc_regfile rtc_regfile_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .addr_odd(addr_odd), .wr_en(wr_en),
  .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .irq(irq), .sec_pulse(sec_pulse),
  .idx(idx), .ctl_b(ctl_b), .ctl_c(ctl_c), .uip(uip), .upd_evt(upd_evt)
);

// File: tb/rtc_regfile_tb.sv
module rtc_regfile_tb;
  localparam int TPS = 32768;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       addr_odd = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq;
  logic       cnt_we = 1'b0;
  logic [3:0] cnt_sel = 4'd0;
  logic [6:0] cnt_val = 7'd0;
  logic       sec_pulse;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rtc_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .addr_odd(addr_odd), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .irq(irq), .cnt_we(cnt_we),
    .cnt_sel(cnt_sel), .cnt_val(cnt_val), .sec_pulse(sec_pulse)
  );

  // {tag code, is_read, addr_odd, data, expected}; tag 0=R1 1=R2 2=R3
  localparam int NV = 25;
  localparam logic [19:0] VEC [NV] = '{
    {2'd0, 1'b0, 1'b0, 8'h8A, 8'h00},  // R1 index 10 with bit 7 dropped
    {2'd1, 1'b1, 1'b1, 8'h00, 8'h26},  // R2
    {2'd1, 1'b0, 1'b0, 8'h0B, 8'h00},
    {2'd1, 1'b1, 1'b1, 8'h00, 8'h02},
    {2'd1, 1'b0, 1'b0, 8'h0C, 8'h00},
    {2'd1, 1'b1, 1'b1, 8'h00, 8'h00},
    {2'd1, 1'b0, 1'b0, 8'h0D, 8'h00},
    {2'd1, 1'b1, 1'b1, 8'h00, 8'h80},
    {2'd2, 1'b0, 1'b1, 8'h00, 8'h00},  // R3 write to D
    {2'd2, 1'b1, 1'b1, 8'h00, 8'h80},
    {2'd2, 1'b0, 1'b0, 8'h0C, 8'h00},
    {2'd2, 1'b0, 1'b1, 8'hFF, 8'h00},  // R3 write to C
    {2'd2, 1'b1, 1'b1, 8'h00, 8'h00},
    {2'd2, 1'b0, 1'b0, 8'h0A, 8'h00},
    {2'd2, 1'b0, 1'b1, 8'hA6, 8'h00},  // R3 UIP bit written 1
    {2'd2, 1'b1, 1'b1, 8'h00, 8'h26},
    {2'd0, 1'b0, 1'b0, 8'h0E, 8'h00},
    {2'd0, 1'b0, 1'b1, 8'h5A, 8'h00},
    {2'd0, 1'b1, 1'b1, 8'h00, 8'h5A},
    {2'd0, 1'b0, 1'b0, 8'hFF, 8'h00},  // R1 index 0x7F
    {2'd0, 1'b0, 1'b1, 8'hC3, 8'h00},
    {2'd0, 1'b1, 1'b1, 8'h00, 8'hC3},
    {2'd0, 1'b0, 1'b0, 8'h0E, 8'h00},
    {2'd0, 1'b1, 1'b1, 8'h00, 8'h5A},
    {2'd0, 1'b1, 1'b0, 8'h00, 8'hFF}   // R1 even read
  };
  localparam string TAGS [3] = '{"R1", "R2", "R3"};

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic host_wr(input logic odd, input logic [7:0] d);
    addr_odd = odd; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic host_rd(input logic odd, output logic [7:0] d);
    addr_odd = odd; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic reg_wr(input logic [7:0] i, input logic [7:0] d);
    host_wr(1'b0, i);
    host_wr(1'b1, d);
  endtask

  task automatic reg_rd(input logic [7:0] i, output logic [7:0] d);
    host_wr(1'b0, i);
    host_rd(1'b1, d);
  endtask

  task automatic chain_wr(input logic [3:0] s, input logic [6:0] v);
    cnt_sel = s; cnt_val = v; cnt_we = 1'b1;
    @(negedge clk);
    cnt_we = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      tick = 1'b1;
      @(negedge clk);
    end
    tick = 1'b0;
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic wait_pulse();
    while (!sec_pulse) @(negedge clk);
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(negedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    logic [7:0] v;
    int c0, p1, p2, npulse;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2", {7'd0, irq}, 8'h00);

    for (int e = 0; e < NV; e++) begin
      if (VEC[e][17]) begin
        host_rd(VEC[e][16], v);
        check(TAGS[VEC[e][19:18]], v, VEC[e][7:0]);
      end else begin
        host_wr(VEC[e][16], VEC[e][15:8]);
      end
    end

    // R10 encoding
    chain_wr(4'd0, 7'd45); reg_rd(8'd0, v); check("R10", v, 8'h45);
    chain_wr(4'd4, 7'd13); reg_rd(8'd4, v); check("R10", v, 8'h13);
    reg_wr(8'd11, 8'h00);
    chain_wr(4'd4, 7'd13); reg_rd(8'd4, v); check("R10", v, 8'h81);
    chain_wr(4'd4, 7'd0);  reg_rd(8'd4, v); check("R10", v, 8'h12);
    chain_wr(4'd4, 7'd12); reg_rd(8'd4, v); check("R10", v, 8'h92);
    reg_wr(8'd11, 8'h04);
    chain_wr(4'd4, 7'd23); reg_rd(8'd4, v); check("R10", v, 8'h8B);
    reg_wr(8'd11, 8'h06);
    chain_wr(4'd0, 7'd45); reg_rd(8'd0, v); check("R10", v, 8'h2D);

    // R7 SET freeze of chain writes, host writes kept
    reg_wr(8'd11, 8'h82);
    chain_wr(4'd0, 7'd30); reg_rd(8'd0, v); check("R7", v, 8'h2D);
    reg_wr(8'd0, 8'h59);   reg_rd(8'd0, v); check("R7", v, 8'h59);
    reg_wr(8'd11, 8'h02);

    // R9 periodic flag, R5 enable behaviour, R4 read-clear
    reg_wr(8'd10, 8'h23);
    ticks(4);
    check("R9", {7'd0, irq}, 8'h00);
    reg_wr(8'd11, 8'h42);
    check("R5", {7'd0, irq}, 8'h01);
    reg_rd(8'd12, v); check("R4", v, 8'hC0);
    check("R4", {7'd0, irq}, 8'h00);
    host_rd(1'b1, v); check("R4", v, 8'h00);
    reg_wr(8'd11, 8'h02);
    ticks(4);
    reg_wr(8'd11, 8'h12);
    check("R5", {7'd0, irq}, 8'h00);
    host_wr(1'b1, 8'h42);
    check("R5", {7'd0, irq}, 8'h01);
    host_wr(1'b1, 8'h02);
    check("R5", {7'd0, irq}, 8'h00);
    reg_rd(8'd12, v); check("R5", v, 8'h40);
    reg_wr(8'd11, 8'h42);
    ticks(4);
    check("R9", {7'd0, irq}, 8'h01);
    reg_rd(8'd12, v); check("R9", v, 8'hC0);
    reg_wr(8'd11, 8'h02);

    // R8 half-second restart, R11 alarm with don't-care bytes
    reg_wr(8'd1, 8'hC0); reg_wr(8'd3, 8'hC0); reg_wr(8'd5, 8'hC0);
    reg_wr(8'd10, 8'h66);
    ticks(5);
    host_wr(1'b1, 8'h26);
    c0 = cyc;
    tick = 1'b1;
    wait_pulse();
    p1 = cyc;
    check("R8", 8'(p1 - c0 == TPS / 2), 8'h01);
    reg_rd(8'd12, v); check("R11", v, 8'h70);
    reg_wr(8'd1, 8'h01);

    // R6 UIP window and second length
    host_wr(1'b0, 8'd10);
    wait_until(p1 + TPS - 9);
    host_rd(1'b1, v); check("R6", v, 8'h26);
    wait_until(p1 + TPS - 7);
    host_rd(1'b1, v); check("R6", v, 8'hA6);
    wait_pulse();
    p2 = cyc;
    check("R6", 8'(p2 - p1 == TPS), 8'h01);
    host_rd(1'b1, v); check("R6", v, 8'h26);
    reg_rd(8'd12, v); check("R11", v, 8'h50);

    // R7 no update while SET
    reg_wr(8'd11, 8'h82);
    npulse = 0;
    repeat (TPS + 16) begin
      @(negedge clk);
      if (sec_pulse) npulse++;
    end
    check("R7", 8'(npulse), 8'h00);
    reg_rd(8'd12, v); check("R7", v & 8'h10, 8'h00);
    reg_wr(8'd11, 8'h02);
    tick = 1'b0;
    report();
  end
endmodule